// File: doc/BRIEF.md
# Serial Packet Transmitter with Automatic Collision Retry

This block turns a packet held by a byte source into a serial bit stream. It runs entirely on the transmit clock, which is nominally 1 MHz. After a start request, it sends a 64-bit training pattern and then the payload bytes, least significant bit first. A line-enable output frames the packet. The block pulls payload bytes from the source one at a time through a take strobe. The source marks the first byte and the last byte of the packet.

Once the training pattern is complete, the block treats the collision input as a sign that the medium was disturbed. It drops the line, pulses a rewind strobe so that the source goes back to the first byte, and starts the whole packet again with no host action. The sixteenth collision in one packet ends the attempt and sets an abort flag. After a packet that completes, the block opens a fixed window of transmit clocks. During this window the collision input is read as the transceiver's heartbeat, and a flag records whether the heartbeat was missing. Backoff delays and fetching the packet from memory are outside this block.

Top module: `serial_tx_retry`

## Requirements
- R1: After reset, `lineEnable`, `serialOut`, `byteTake`, `rewind`, `done`, `aborted` and `hbMissing` are all 0.
- R2: `start` is accepted only while the block is idle and `byteFirst` is 1. At any other time it has no effect. When it is accepted, `lineEnable` rises at the next clock edge, together with the first pattern bit (a 1) on `serialOut`.
- R3: The training pattern is 64 bits. Bits 0 to 61 alternate and begin with 1, so an even index gives 1 and an odd index gives 0. Bits 62 and 63 are both 1.
- R4: Payload bits follow the pattern with no gap, least significant bit first. `byteTake` is 1 during the cycle in which the last pattern bit, or the last bit of a byte that is not the last byte, is on the line. `byteData` and `byteLast` are sampled at the end of that cycle.
- R5: `lineEnable` falls at the clock edge that ends the last bit of the byte marked `byteLast`. `serialOut` is 0 whenever `lineEnable` is 0.
- R6: `collisionIn` has no effect while any of the 64 pattern bits is on the line.
- R7: If `collisionIn` is 1 at the end of a payload bit cycle, and fewer than 15 retries have been used, then `lineEnable` is 0 in the next cycle and `rewind` is 1 for exactly that one cycle. In the first later cycle in which `byteFirst` is 1, the packet restarts from the first pattern bit.
- R8: A collision that arrives when 15 retries have already been used sets `aborted` and `done`, produces no `rewind`, and returns the block to idle.
- R9: After `lineEnable` falls at the end of a packet, a window of HB_WINDOW cycles is examined. At the end of the window, `done` is set, and `hbMissing` is set if and only if `collisionIn` was 0 throughout the window.
- R10: `done`, `aborted` and `hbMissing` hold their values until the next accepted start, which clears them. Each accepted start also resets the retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send the packet offered by the source |
| byteData | input | BYTE_W | Payload byte currently offered by the source |
| byteFirst | input | 1 | The offered byte is the first byte of the packet |
| byteLast | input | 1 | The offered byte is the last byte of the packet |
| collisionIn | input | 1 | Collision indication during the payload, heartbeat after the packet |
| serialOut | output | 1 | Serial line data |
| lineEnable | output | 1 | High while a packet bit is on the line |
| byteTake | output | 1 | The offered byte is consumed at the end of this cycle |
| rewind | output | 1 | One-cycle request for the source to return to the first byte |
| done | output | 1 | Packet finished, either after the heartbeat window or by abort |
| aborted | output | 1 | Packet given up after too many collisions |
| hbMissing | output | 1 | No heartbeat was seen in the window after the packet |

## Verification
The embedded assertions check these rules on every cycle:
- a low line enable forces the data line low;
- the datapath strobes are mutually exclusive;
- a newly enabled line starts with a 1;
- a collision during the pattern leaves the packet running;
- a payload collision produces either a counted rewind or an abort;
- the heartbeat flag rises together with `done`;
- an accepted start clears every status flag.

Only the scenarios can show the rest. This includes the exact bit sequence of the pattern and of the payload, the cycle in which each byte is taken, and the heartbeat decision for both present and absent pulses. It also includes how the block waits for the source to rewind, that exactly fifteen retries happen before an abort, and that a start is ignored when the first-byte marker is low or the block is busy.

// File: rtl/txser_pkg.sv
package txser_pkg;

  localparam int PRE_LEN   = 64;
  localparam int PRE_CNT_W = $clog2(PRE_LEN);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DATA,
    S_REWIND,
    S_WAITF,
    S_HB
  } txState_t;

  typedef struct packed {
    logic preLoad;
    logic preBit;
    logic byteLoad;
    logic bitShift;
    logic lineOff;
  } dpStrobe_t;

  // Training pattern: alternating bits starting at 1, last two bits both 1.
  function automatic logic preambleBit(input logic [PRE_CNT_W-1:0] idx);
    return (idx == PRE_CNT_W'(PRE_LEN - 1)) | ~idx[0];
  endfunction

endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import txser_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int HB_WINDOW = 8,
  parameter int MAX_RETRY = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      byteFirst,
  input  logic      collisionIn,
  input  logic      lastByte,
  output dpStrobe_t strb,
  output logic      byteTake,
  output logic      rewind,
  output logic      done,
  output logic      aborted,
  output logic      hbMissing
);

  localparam int BIT_IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int HB_CNT_W  = $clog2(HB_WINDOW + 1);
  localparam int RETRY_W   = $clog2(MAX_RETRY + 1);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [HB_CNT_W-1:0]  HB_LAST   = HB_CNT_W'(HB_WINDOW - 1);
  localparam logic [RETRY_W-1:0]   RETRY_CAP = RETRY_W'(MAX_RETRY);
  localparam logic [PRE_CNT_W-1:0] PRE_LAST  = PRE_CNT_W'(PRE_LEN - 1);

  txState_t               stateQ;
  logic [PRE_CNT_W-1:0]   preCnt;
  logic [BIT_IDX_W-1:0]   bitIdx;
  logic [HB_CNT_W-1:0]    hbCnt;
  logic                   hbSeen;
  logic [RETRY_W-1:0]     retryCnt;
  logic                   accepted;

  assign accepted = (stateQ == S_IDLE) && start && byteFirst;
  assign rewind   = (stateQ == S_REWIND);

  always_comb begin
    strb     = '0;
    byteTake = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (accepted) begin
          strb.preLoad = 1'b1;
          strb.preBit  = preambleBit('0);
        end
      end
      S_PRE: begin
        byteTake = (preCnt == PRE_LAST);
        if (preCnt == PRE_LAST) begin
          strb.byteLoad = 1'b1;
        end else begin
          strb.preLoad = 1'b1;
          strb.preBit  = preambleBit(preCnt + 1'b1);
        end
      end
      S_DATA: begin
        byteTake = (bitIdx == LAST_BIT) && !lastByte;
        if (collisionIn)                strb.lineOff  = 1'b1;
        else if (bitIdx != LAST_BIT)    strb.bitShift = 1'b1;
        else if (lastByte)              strb.lineOff  = 1'b1;
        else                            strb.byteLoad = 1'b1;
      end
      S_WAITF: begin
        if (byteFirst) begin
          strb.preLoad = 1'b1;
          strb.preBit  = preambleBit('0);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      preCnt    <= '0;
      bitIdx    <= '0;
      hbCnt     <= '0;
      hbSeen    <= 1'b0;
      retryCnt  <= '0;
      done      <= 1'b0;
      aborted   <= 1'b0;
      hbMissing <= 1'b0;
    end else begin
      unique case (stateQ)
        S_IDLE: begin
          if (accepted) begin
            stateQ    <= S_PRE;
            preCnt    <= '0;
            retryCnt  <= '0;
            done      <= 1'b0;
            aborted   <= 1'b0;
            hbMissing <= 1'b0;
          end
        end
        S_PRE: begin
          if (preCnt == PRE_LAST) begin
            stateQ <= S_DATA;
            bitIdx <= '0;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (collisionIn) begin
            if (retryCnt == RETRY_CAP) begin
              aborted <= 1'b1;
              done    <= 1'b1;
              stateQ  <= S_IDLE;
            end else begin
              retryCnt <= retryCnt + 1'b1;
              stateQ   <= S_REWIND;
            end
          end else if (bitIdx == LAST_BIT) begin
            bitIdx <= '0;
            if (lastByte) begin
              stateQ <= S_HB;
              hbCnt  <= '0;
              hbSeen <= 1'b0;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        S_REWIND: stateQ <= S_WAITF;
        S_WAITF: begin
          if (byteFirst) begin
            stateQ <= S_PRE;
            preCnt <= '0;
          end
        end
        S_HB: begin
          if (collisionIn) hbSeen <= 1'b1;
          if (hbCnt == HB_LAST) begin
            done      <= 1'b1;
            hbMissing <= !(hbSeen || collisionIn);
            stateQ    <= S_IDLE;
          end else begin
            hbCnt <= hbCnt + 1'b1;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  // R6
  preamble_col_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_PRE && collisionIn) |=> (stateQ == S_PRE || stateQ == S_DATA));

  // R7
  collision_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DATA && collisionIn && retryCnt != RETRY_CAP)
      |=> (rewind && retryCnt == $past(retryCnt) + 1'b1));

  // R8
  collision_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DATA && collisionIn && retryCnt == RETRY_CAP)
      |=> (aborted && done && !rewind));

  // R9
  hb_flag_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hbMissing) |-> $rose(done));

  // R10
  start_clears_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (!done && !aborted && !hbMissing));

endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import txser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteLast,
  output logic              serialOut,
  output logic              lineEnable,
  output logic              lastByte
);

  logic [BYTE_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialOut  <= 1'b0;
      lineEnable <= 1'b0;
      shiftQ     <= '0;
      lastByte   <= 1'b0;
    end else if (strb.lineOff) begin
      serialOut  <= 1'b0;
      lineEnable <= 1'b0;
    end else if (strb.preLoad) begin
      serialOut  <= strb.preBit;
      lineEnable <= 1'b1;
    end else if (strb.byteLoad) begin
      serialOut <= byteData[0];
      shiftQ    <= byteData >> 1;
      lastByte  <= byteLast;
    end else if (strb.bitShift) begin
      serialOut <= shiftQ[0];
      shiftQ    <= shiftQ >> 1;
    end
  end

  // R5
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnable |-> !serialOut);

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.preLoad, strb.byteLoad, strb.bitShift, strb.lineOff}));

endmodule

// File: rtl/serial_tx_retry.sv
module serial_tx_retry
  import txser_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int HB_WINDOW = 8,
  parameter int MAX_RETRY = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteFirst,
  input  logic              byteLast,
  input  logic              collisionIn,
  output logic              serialOut,
  output logic              lineEnable,
  output logic              byteTake,
  output logic              rewind,
  output logic              done,
  output logic              aborted,
  output logic              hbMissing
);

  dpStrobe_t strb;
  logic      lastByte;

  txCtrl #(
    .BYTE_W   (BYTE_W),
    .HB_WINDOW(HB_WINDOW),
    .MAX_RETRY(MAX_RETRY)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .byteFirst  (byteFirst),
    .collisionIn(collisionIn),
    .lastByte   (lastByte),
    .strb       (strb),
    .byteTake   (byteTake),
    .rewind     (rewind),
    .done       (done),
    .aborted    (aborted),
    .hbMissing  (hbMissing)
  );

  txDatapath #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteData  (byteData),
    .byteLast  (byteLast),
    .serialOut (serialOut),
    .lineEnable(lineEnable),
    .lastByte  (lastByte)
  );

  // R2
  first_bit_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineEnable) |-> serialOut);

endmodule

// File: tb/serial_tx_retry_tb.sv
module serial_tx_retry_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HB_WIN     = 8;
  localparam int WD_CYCLES  = 20000;
  localparam int M_IDLE = 0, M_SEND = 1, M_REW = 2, M_WAIT = 3, M_HB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic collide = 1'b0;
  logic [7:0] pkt [16];
  int   pktLen = 1;
  logic [3:0] srcIdx = '0;
  logic srcLoad = 1'b0;
  logic [3:0] srcLoadVal = '0;

  logic [7:0] byteData;
  logic byteFirst, byteLast;
  logic serialOut, lineEnable, byteTake, rewind, done, aborted, hbMissing;

  assign byteData  = pkt[srcIdx];
  assign byteFirst = (srcIdx == 4'd0);
  assign byteLast  = (int'(srcIdx) == pktLen - 1);

  serial_tx_retry #(.BYTE_W(8), .HB_WINDOW(HB_WIN), .MAX_RETRY(15)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .byteData(byteData),
    .byteFirst(byteFirst), .byteLast(byteLast), .collisionIn(collide),
    .serialOut(serialOut), .lineEnable(lineEnable), .byteTake(byteTake),
    .rewind(rewind), .done(done), .aborted(aborted), .hbMissing(hbMissing)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Byte source: rewinds on request, advances on take.
  always @(posedge clk) begin
    if (srcLoad)       srcIdx <= srcLoadVal;
    else if (rewind)   srcIdx <= '0;
    else if (byteTake) srcIdx <= srcIdx + 4'd1;
  end

  // Behavioural reference model
  int mMode, mIdx, mN, mHb, mRetry;
  bit mSeen, mDone, mAbort, mHbMiss;

  function automatic bit wireBit(int i);
    if (i < 64) return (i == 63) ? 1'b1 : (i % 2 == 0);
    return pkt[(i - 64) / 8][(i - 64) % 8];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = M_IDLE; mIdx = 0; mN = 0; mHb = 0; mRetry = 0;
      mSeen = 0; mDone = 0; mAbort = 0; mHbMiss = 0;
    end else begin
      case (mMode)
        M_IDLE: if (start && byteFirst) begin
          mMode = M_SEND; mIdx = 0; mN = 64 + 8 * pktLen; mRetry = 0;
          mDone = 0; mAbort = 0; mHbMiss = 0;
        end
        M_SEND: begin
          if (collide && mIdx >= 64) begin
            if (mRetry == 15) begin mAbort = 1; mDone = 1; mMode = M_IDLE; end
            else begin mRetry++; mMode = M_REW; end
          end else if (mIdx == mN - 1) begin
            mMode = M_HB; mHb = 0; mSeen = 0;
          end else mIdx++;
        end
        M_REW: mMode = M_WAIT;
        M_WAIT: if (byteFirst) begin mMode = M_SEND; mIdx = 0; end
        M_HB: begin
          if (collide) mSeen = 1;
          if (mHb == HB_WIN - 1) begin mDone = 1; mHbMiss = !mSeen; mMode = M_IDLE; end
          else mHb++;
        end
        default: mMode = M_IDLE;
      endcase
    end
  end

  int vectors = 0, miscompares = 0, cycles = 0, rewCount = 0;
  bit finished = 0;

  task automatic cmp(input string what, input logic act, input logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", what, act, exp, cycles);
    end
  endtask

  task automatic check(input string what, input logic act, input logic exp);
    vectors++;
    cmp(what, act, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    bit eTake;
    cycles++;
    if (rewind === 1'b1) rewCount++;
    eTake = (mMode == M_SEND) && mIdx >= 63 && ((mIdx - 63) % 8 == 0) && mIdx < mN - 1;
    vectors++;
    cmp("R1/R2/R5 lineEnable",   lineEnable, mMode == M_SEND);
    cmp("R3/R4 serialOut",       serialOut,  (mMode == M_SEND) ? wireBit(mIdx) : 1'b0);
    cmp("R4 byteTake",           byteTake,   eTake);
    cmp("R7 rewind",             rewind,     mMode == M_REW);
    cmp("R9/R10 done",           done,       mDone);
    cmp("R8 aborted",            aborted,    mAbort);
    cmp("R9 hbMissing",          hbMissing,  mHbMiss);
    if (cycles > WD_CYCLES) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WD_CYCLES);
      summary();
    end
  end

  task automatic loadPacket(input int len, input int seed, input logic [3:0] at);
    for (int i = 0; i < 16; i++) pkt[i] = 8'(i * 53 + seed) ^ 8'h3C;
    pktLen = len;
    @(negedge clk); srcLoad = 1'b1; srcLoadVal = at;
    @(negedge clk); srcLoad = 1'b0;
  endtask

  // Leaves the caller in the negedge of the cycle showing bit 0.
  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic giveHeartbeat();
    while (mMode != M_HB) @(negedge clk);
    repeat (2) @(negedge clk);
    collide = 1'b1;
    @(negedge clk); collide = 1'b0;
  endtask

  task automatic waitDone();
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pkt[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lineEnable at reset", lineEnable, 1'b0);
    check("R1 done at reset", done, 1'b0);
    check("R1 hbMissing at reset", hbMissing, 1'b0);
    rstN = 1'b1;

    // R9 frame of three bytes with heartbeat
    loadPacket(3, 7, 4'd0);
    pulseStart();
    giveHeartbeat();
    waitDone();
    check("R9 hbMissing with heartbeat", hbMissing, 1'b0);

    // R9 single byte frame without heartbeat
    loadPacket(1, 91, 4'd0);
    pulseStart();
    waitDone();
    check("R9 hbMissing without heartbeat", hbMissing, 1'b1);

    // R2 start ignored when source not at first byte; R10 status kept
    loadPacket(2, 3, 4'd1);
    pulseStart();
    repeat (5) @(negedge clk);
    check("R2 lineEnable after refused start", lineEnable, 1'b0);
    check("R10 hbMissing held", hbMissing, 1'b1);

    // R6 collisions in the pattern ignored; R2 start while busy ignored
    loadPacket(4, 200, 4'd0);
    pulseStart();
    repeat (10) @(negedge clk); collide = 1'b1;
    @(negedge clk); collide = 1'b0;
    repeat (18) @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (33) @(negedge clk); collide = 1'b1;
    @(negedge clk); collide = 1'b0;
    giveHeartbeat();
    waitDone();
    check("R6 no rewind from pattern collisions", rewCount == 0, 1'b1);
    check("R6 not aborted", aborted, 1'b0);

    // R7 single payload collision then success
    loadPacket(2, 17, 4'd0);
    pulseStart();
    repeat (40) @(negedge clk); collide = 1'b1;
    repeat (25) @(negedge clk); collide = 1'b0;
    giveHeartbeat();
    waitDone();
    check("R7 one rewind", rewCount == 1, 1'b1);
    check("R7 completed after retry", aborted, 1'b0);

    // R8 collisions on every attempt until abort
    rewCount = 0;
    loadPacket(2, 60, 4'd0);
    pulseStart();
    collide = 1'b1;
    while (aborted !== 1'b1) @(negedge clk);
    collide = 1'b0;
    check("R8 fifteen rewinds before abort", rewCount == 15, 1'b1);
    check("R8 done with abort", done, 1'b1);
    repeat (4) @(negedge clk);
    check("R8 line idle after abort", lineEnable, 1'b0);

    // R10 new start clears abort and runs normally
    loadPacket(5, 33, 4'd0);
    pulseStart();
    @(negedge clk);
    check("R10 aborted cleared by start", aborted, 1'b0);
    check("R10 done cleared by start", done, 1'b0);
    giveHeartbeat();
    waitDone();
    check("R9 done after window", done, 1'b1);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule